// File: doc/BRIEF.md
# Line-21 Caption Data Encoder

This block produces the serial bit stream for closed-caption data on one chosen video line per field. Two 8-bit byte pairs are presented on its inputs: one pair for the odd field (caption data) and one for the even field (extended data). When the upstream line timer announces the start of the selected line, the block takes a snapshot of the pair that belongs to the current field. After a programmable horizontal delay it sends a clock run-in, a three-bit framing code and then both bytes.

The output is a one-bit data level together with a valid window. A downstream luminance inserter shapes these into the analog waveform. Bytes are sent least significant bit first. The most significant bit of each byte is the parity bit supplied by the caller, and the block sends it unchanged. Each bit is held for a programmable number of pixel clocks.

Top module: `cc_line21_enc`

## Requirements
- R1: While reset is asserted, and after it, until a frame starts, `capValid` and `capData` are 0.
- R2: A frame opens with a run-in of 14 bits that alternate, starting with 1 (1,0,1,0,...).
- R3: The framing bits 0, 0, 1 follow the run-in directly, in that order.
- R4: After the framing bits, byte 0 is sent and then byte 1, each least significant bit first. Bit 7 of each byte is sent exactly as supplied.
- R5: When `oddField` is 1 at the line strobe, the odd byte pair is sent. Otherwise the even byte pair is sent.
- R6: A frame starts only when `lineIndex` equals `lineSel + 4` (`sys525`=1) or `lineSel + 1` (`sys525`=0). On any other line the outputs stay at 0.
- R7: `capValid` rises `startDelay`+1 clock cycles after the clock edge that samples the line strobe. It stays high for exactly 33 bit periods.
- R8: Each bit lasts `bitPeriod` clock cycles. A `bitPeriod` of 0 is treated as 1.
- R9: If the enable for the current field (`oddEnable` or `evenEnable`) is 0 at the line strobe, `capValid` and `capData` stay 0 for that line.
- R10: The byte values are captured at the line strobe. Changes to the byte inputs during a frame do not alter the bits being sent.
- R11: `capData` is 0 whenever `capValid` is 0.
- R12: A line strobe that arrives while a frame is pending or being sent is ignored. No second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStrobe | input | 1 | One-cycle pulse at the start of each line |
| oddField | input | 1 | 1 during the odd field |
| lineIndex | input | 10 | Current line number within the field |
| sys525 | input | 1 | 1 selects the 525-line offset |
| lineSel | input | 5 | Programmed line select |
| startDelay | input | 11 | Clocks from the line strobe to the first run-in bit, minus one |
| bitPeriod | input | 8 | Clocks per bit |
| oddEnable | input | 1 | Encode in the odd field |
| evenEnable | input | 1 | Encode in the even field |
| oddByte0 | input | 8 | First odd-field byte |
| oddByte1 | input | 8 | Second odd-field byte |
| evenByte0 | input | 8 | First even-field byte |
| evenByte1 | input | 8 | Second even-field byte |
| capData | output | 1 | Serial data level |
| capValid | output | 1 | High while the frame is being sent |

## Verification
A wrong frame register shows at the data output as a wrong bit in the very bit period it occupies. A stray shift or a missed load shows as every later bit being displaced. A fault in the control counters moves the valid window edges by whole cycles: a start late or early by the delay, or an end shortened by the bit index. The bench compares both outputs on every clock of every line it drives, so each fault is reported in the first cycle in which it differs.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int RUNIN_CYCLES = 7;
  localparam int RUNIN_BITS   = 2 * RUNIN_CYCLES;
  localparam int FRAMING_BITS = 3;
  localparam int DATA_BITS    = 16;
  localparam int FRAME_BITS   = RUNIN_BITS + FRAMING_BITS + DATA_BITS;
  localparam int IDX_W        = $clog2(FRAME_BITS);

  typedef struct packed {
    logic load;
    logic loadOdd;
    logic shift;
    logic sending;
  } ccStrobe_t;

  typedef enum logic [1:0] {
    CC_IDLE = 2'd0,
    CC_WAIT = 2'd1,
    CC_SEND = 2'd2
  } ccState_t;
endpackage

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int SEL_W       = 5,
  parameter int HPOS_W      = 11,
  parameter int BITP_W      = 8,
  parameter int LINE_OFS525 = 4,
  parameter int LINE_OFSOTH = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              oddField,
  input  logic [LINE_W-1:0] lineIndex,
  input  logic              sys525,
  input  logic [SEL_W-1:0]  lineSel,
  input  logic [HPOS_W-1:0] startDelay,
  input  logic [BITP_W-1:0] bitPeriod,
  input  logic              oddEnable,
  input  logic              evenEnable,
  output ccStrobe_t         strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  ccState_t          state;
  logic [HPOS_W-1:0] delayCnt;
  logic [BITP_W-1:0] periodCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [LINE_W-1:0] targetLine;
  logic [BITP_W-1:0] effPeriod;
  logic              lineHit;
  logic              fieldEn;
  logic              lastPer;

  always_comb begin
    targetLine = LINE_W'(lineSel) + (sys525 ? LINE_W'(LINE_OFS525) : LINE_W'(LINE_OFSOTH));
    lineHit    = (lineIndex == targetLine);
    fieldEn    = oddField ? oddEnable : evenEnable;
    effPeriod  = (bitPeriod == '0) ? BITP_W'(1) : bitPeriod;
    lastPer    = (periodCnt == effPeriod - BITP_W'(1));
    strobe.load    = (state == CC_IDLE) && lineStrobe && lineHit && fieldEn;
    strobe.loadOdd = oddField;
    strobe.sending = (state == CC_SEND);
    strobe.shift   = (state == CC_SEND) && lastPer;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= CC_IDLE;
      delayCnt  <= '0;
      periodCnt <= '0;
      bitIdx    <= '0;
    end else begin
      case (state)
        CC_IDLE: begin
          if (strobe.load) begin
            state    <= CC_WAIT;
            delayCnt <= startDelay;
          end
        end
        CC_WAIT: begin
          if (delayCnt == '0) begin
            state     <= CC_SEND;
            periodCnt <= '0;
            bitIdx    <= '0;
          end else begin
            delayCnt <= delayCnt - HPOS_W'(1);
          end
        end
        CC_SEND: begin
          if (lastPer) begin
            periodCnt <= '0;
            if (bitIdx == LAST_IDX) state <= CC_IDLE;
            else bitIdx <= bitIdx + IDX_W'(1);
          end else begin
            periodCnt <= periodCnt + BITP_W'(1);
          end
        end
        default: state <= CC_IDLE;
      endcase
    end
  end

  // R7: a frame ends only after its last bit
  a_r7_full_frame: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.sending) |-> ($past(bitIdx) == LAST_IDX));

  // R12: capture happens only when no frame is pending
  a_r12_load_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (state == CC_WAIT));

  // R8: the period counter never passes the effective period
  a_r8_period_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == CC_SEND) && $stable(bitPeriod) |-> (periodCnt < effPeriod));
endmodule

// File: rtl/cc_datapath.sv
module cc_datapath
  import cc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ccStrobe_t strobe,
  input  logic [7:0] oddByte0,
  input  logic [7:0] oddByte1,
  input  logic [7:0] evenByte0,
  input  logic [7:0] evenByte1,
  output logic      capData,
  output logic      capValid
);
  logic [FRAME_BITS-1:0] frameReg;
  logic [RUNIN_BITS-1:0] runIn;
  logic [7:0]            selByte0;
  logic [7:0]            selByte1;

  genvar gi;
  generate
    for (gi = 0; gi < RUNIN_BITS; gi++) begin : g_runin
      assign runIn[gi] = ((gi % 2) == 0);
    end
  endgenerate

  always_comb begin
    selByte0 = strobe.loadOdd ? oddByte0 : evenByte0;
    selByte1 = strobe.loadOdd ? oddByte1 : evenByte1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '0;
    end else if (strobe.load) begin
      frameReg <= {selByte1, selByte0, 3'b100, runIn};
    end else if (strobe.shift) begin
      frameReg <= {1'b0, frameReg[FRAME_BITS-1:1]};
    end
  end

  assign capValid = strobe.sending;
  assign capData  = strobe.sending & frameReg[0];

  // R10: the snapshot holds unless loaded or shifted
  a_r10_snapshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load && !strobe.shift |=> $stable(frameReg));

  // R12: a load never happens while bits are going out
  a_r12_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.sending));
endmodule

// File: rtl/cc_line21_enc.sv
module cc_line21_enc
  import cc_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int SEL_W       = 5,
  parameter int HPOS_W      = 11,
  parameter int BITP_W      = 8,
  parameter int LINE_OFS525 = 4,
  parameter int LINE_OFSOTH = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              oddField,
  input  logic [LINE_W-1:0] lineIndex,
  input  logic              sys525,
  input  logic [SEL_W-1:0]  lineSel,
  input  logic [HPOS_W-1:0] startDelay,
  input  logic [BITP_W-1:0] bitPeriod,
  input  logic              oddEnable,
  input  logic              evenEnable,
  input  logic [7:0]        oddByte0,
  input  logic [7:0]        oddByte1,
  input  logic [7:0]        evenByte0,
  input  logic [7:0]        evenByte1,
  output logic              capData,
  output logic              capValid
);
  ccStrobe_t strobe;

  cc_ctrl #(
    .LINE_W(LINE_W), .SEL_W(SEL_W), .HPOS_W(HPOS_W), .BITP_W(BITP_W),
    .LINE_OFS525(LINE_OFS525), .LINE_OFSOTH(LINE_OFSOTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .oddField(oddField),
    .lineIndex(lineIndex), .sys525(sys525), .lineSel(lineSel),
    .startDelay(startDelay), .bitPeriod(bitPeriod),
    .oddEnable(oddEnable), .evenEnable(evenEnable), .strobe(strobe)
  );

  cc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .oddByte0(oddByte0), .oddByte1(oddByte1),
    .evenByte0(evenByte0), .evenByte1(evenByte1),
    .capData(capData), .capValid(capValid)
  );

  // R2: the first bit of every frame is a 1
  a_r2_runin_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capValid) |-> capData);

  // R11: no data level outside the window
  a_r11_blank: assert property (@(posedge clk) disable iff (!rstN)
    !capValid |-> !capData);
endmodule

// File: tb/cc_line21_enc_test.sv
module cc_line21_enc_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStrobe = 1'b0;
  logic oddField = 1'b1;
  logic [9:0] lineIndex = '0;
  logic sys525 = 1'b1;
  logic [4:0] lineSel = 5'd17;
  logic [10:0] startDelay = '0;
  logic [7:0] bitPeriod = 8'd1;
  logic oddEnable = 1'b1;
  logic evenEnable = 1'b1;
  logic [7:0] oddByte0 = '0, oddByte1 = '0, evenByte0 = '0, evenByte1 = '0;
  logic capData, capValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cc_line21_enc uut (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .oddField(oddField),
    .lineIndex(lineIndex), .sys525(sys525), .lineSel(lineSel),
    .startDelay(startDelay), .bitPeriod(bitPeriod),
    .oddEnable(oddEnable), .evenEnable(evenEnable),
    .oddByte0(oddByte0), .oddByte1(oddByte1),
    .evenByte0(evenByte0), .evenByte1(evenByte1),
    .capData(capData), .capValid(capValid)
  );

  function automatic bit expBit(int k, logic [7:0] b0, logic [7:0] b1);
    if (k < 14) return (k % 2) == 0;
    if (k < 16) return 1'b0;
    if (k == 16) return 1'b1;
    if (k < 25) return b0[k-17];
    return b1[k-25];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drives one line strobe and compares both outputs on every following clock.
  task automatic runLine(bit odd, int lineIx, bit expAct, logic [7:0] b0,
                         logic [7:0] b1, int d, int p, bit disturb, string req);
    int pe = (p == 0) ? 1 : p;
    int last = d + 33 * pe;
    oddField   = odd;
    lineIndex  = 10'(lineIx);
    startDelay = 11'(d);
    bitPeriod  = 8'(p);
    lineStrobe = 1'b1;
    @(posedge clk); #1;
    lineStrobe = 1'b0;
    for (int n = 1; n <= last + 4; n++) begin
      bit ev, ed;
      @(posedge clk); #1;
      ev = expAct && (n >= d + 1) && (n <= last);
      ed = ev ? expBit((n - d - 1) / pe, b0, b1) : 1'b0;
      check(capValid == ev, {req, " valid window R7"}, int'(capValid), int'(ev));
      check(capData == ed, {req, " data"}, int'(capData), int'(ed));
      if (disturb && n == d + 4) begin
        oddByte0 = ~oddByte0; oddByte1 = ~oddByte1;
        evenByte0 = ~evenByte0; evenByte1 = ~evenByte1;
      end
      if (disturb && n == d + 8) lineStrobe = 1'b1;
      if (disturb && n == d + 9) lineStrobe = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    check(capValid == 1'b0, "R1 reset valid", int'(capValid), 0);
    check(capData == 1'b0, "R1 reset data", int'(capData), 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(capValid == 1'b0, "R1 after reset", int'(capValid), 0);

    // R2 R3 R4 R7 R8: sweep delay and bit period over both fields (R5)
    for (int di = 0; di < 3; di++) begin
      for (int pi = 0; pi < 4; pi++) begin
        int dl = di * 3;
        logic [7:0] a = 8'(8'h35 + di * 37 + pi * 11);
        logic [7:0] b = 8'(8'hC2 ^ (di * 19 + pi * 5));
        oddByte0 = a; oddByte1 = b;
        evenByte0 = ~b; evenByte1 = ~a;
        runLine(1'b1, 21, 1'b1, a, b, dl, pi, 1'b0, "R2 R3 R4 R5 R8 odd");
        runLine(1'b0, 21, 1'b1, ~b, ~a, dl, pi, 1'b0, "R4 R5 R8 even");
      end
    end

    // R4: parity bit (bit 7) set and clear, sent as supplied
    oddByte0 = 8'h80; oddByte1 = 8'h7F;
    runLine(1'b1, 21, 1'b1, 8'h80, 8'h7F, 1, 2, 1'b0, "R4 msb");

    // R6: line offset for each system
    sys525 = 1'b0;
    runLine(1'b1, 18, 1'b1, 8'h80, 8'h7F, 0, 1, 1'b0, "R6 other-system hit");
    runLine(1'b1, 21, 1'b0, 8'h80, 8'h7F, 0, 1, 1'b0, "R6 other-system miss");
    sys525 = 1'b1;
    runLine(1'b1, 22, 1'b0, 8'h80, 8'h7F, 0, 1, 1'b0, "R6 wrong line");
    lineSel = 5'd31;
    runLine(1'b0, 35, 1'b1, evenByte0, evenByte1, 2, 1, 1'b0, "R6 max select");
    lineSel = 5'd17;

    // R9: per-field enable
    oddEnable = 1'b0;
    runLine(1'b1, 21, 1'b0, oddByte0, oddByte1, 0, 1, 1'b0, "R9 odd disabled R11");
    runLine(1'b0, 21, 1'b1, evenByte0, evenByte1, 0, 1, 1'b0, "R9 even still on");
    oddEnable = 1'b1; evenEnable = 1'b0;
    runLine(1'b0, 21, 1'b0, evenByte0, evenByte1, 0, 1, 1'b0, "R9 even disabled");
    evenEnable = 1'b1;

    // R10 R12: byte writes and a second strobe mid-frame
    oddByte0 = 8'hA6; oddByte1 = 8'h19;
    runLine(1'b1, 21, 1'b1, 8'hA6, 8'h19, 2, 3, 1'b1, "R10 R12 odd");
    evenByte0 = 8'h5B; evenByte1 = 8'hE0;
    runLine(1'b0, 21, 1'b1, 8'h5B, 8'hE0, 0, 2, 1'b1, "R10 R12 even");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule